// File: doc/BRIEF.md
# Tick-Based PWM Generator with Auto-Off Timer

This block makes one pulse-width-modulated output whose period and high time are counted in ticks of a slow time base. The time base comes from the system clock through a fixed-ratio prescaler. A host programs the block through a write-only port with a byte-wide address and a byte-wide data bus. Each 16-bit setting (period, duty, auto-off limit) is written as two bytes. The high byte is only held in a staging flop. The low-byte write loads the whole 16-bit value in one step, so the host never sees a half-updated value.

An enable bit starts and stops the output. Every period starts with the high phase, and only normal polarity is produced. When the duty is equal to or longer than the period, the output stays high for the whole cycle. A period of zero keeps the output low. A 16-bit auto-off timer counts ticks while the output is enabled and clears the enable bit when it reaches its programmed limit. The all-ones limit turns this timer off. Nothing in the block can be read back.

Top module: `pwm_autooff`

## Requirements
- R1: After reset the output is low, enable is 0, period and duty are 0, and the auto-off limit is 0xFFFF (timer off).
- R2: The tick fires once every TICK_DIV system clocks. Period and duty are counted in ticks.
- R3: Writes to 0xA5 (period high), 0xA7 (duty high) and 0xA1 (auto-off high) only stage the byte and change nothing at the output.
- R4: A write to 0xA4 (period low) loads {staged high, data} as the period and restarts the cycle at its first tick, using the duty setting as it was at that edge.
- R5: A write to 0xA6 (duty low) loads {staged high, data} as the duty. The running output picks it up at the next period boundary.
- R6: While running with period N > 0 and duty D < N, each period lasts N ticks. The output is high for the first D ticks and then low.
- R7: When the duty is greater than or equal to a nonzero period, the output stays high for the whole period.
- R8: Bit 0 of a write to 0xA3 sets enable and the other bits are ignored. With enable at 0, the output is low.
- R9: A period of 0 holds the output low even when enable is 1.
- R10: With a limit L other than 0xFFFF, enable clears one clock after L ticks have been counted since the last write to 0xA3 or 0xA2. A new write to 0xA3 restarts the count.
- R11: A write to 0xA2 (auto-off low) loads the limit from {staged high, data}. The limit 0xFFFF stops the count, so the output never times out.
- R12: Writes to addresses outside 0xA1..0xA7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr | input | ADDR_W (8) | Register address |
| wr_data | input | DATA_W (8) | Write data byte |
| pwm_out | output | 1 | PWM output, normal polarity |

## Verification
The output is decoded without a further flop from the period counter, the live duty and the enable bit. A write sampled on a rising edge therefore shows at the pin right after that edge. A duty change waits for the next period wrap. Auto-off drops the pin one clock after the tick count reaches the limit, and each period boundary lands on a tick edge, which comes every TICK_DIV clocks. The bench keeps a behavioural model that steps on every rising edge, including the two-stage reset release. It compares the pin on every falling edge, so each latency shows up in the exact cycle it is due. Windowed high-time counts over whole periods check the duty ratios independently of phase.

// File: rtl/pwm_ao_pkg.sv
package pwm_ao_pkg;

  localparam logic [7:0] A_AUTOOFF_HI = 8'hA1;
  localparam logic [7:0] A_AUTOOFF_LO = 8'hA2;
  localparam logic [7:0] A_ENABLE     = 8'hA3;
  localparam logic [7:0] A_PERIOD_LO  = 8'hA4;
  localparam logic [7:0] A_PERIOD_HI  = 8'hA5;
  localparam logic [7:0] A_DUTY_LO    = 8'hA6;
  localparam logic [7:0] A_DUTY_HI    = 8'hA7;

  typedef struct packed {
    logic ao_hi;
    logic ao_lo;
    logic enable;
    logic per_lo;
    logic per_hi;
    logic duty_lo;
    logic duty_hi;
  } wr_sel_t;

endpackage

// File: rtl/pwm_ao_tick.sv
module pwm_ao_tick #(
  parameter int TICK_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] pc_q, pc_d;

      always_comb begin
        if (pc_q == LAST) pc_d = '0;
        else              pc_d = pc_q + PW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
      end

      assign tick = (pc_q == LAST);

      // R2
      tick_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/pwm_ao_regs.sv
module pwm_ao_regs
  import pwm_ao_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  localparam int CW = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ao_expire,
  output logic              en,
  output logic [CW-1:0]     period,
  output logic [CW-1:0]     duty_cfg,
  output logic [CW-1:0]     ao_limit,
  output logic              per_commit,
  output logic              en_write,
  output logic              ao_commit
);
  wr_sel_t sel;

  logic [DATA_W-1:0] per_hi_q, duty_hi_q, ao_hi_q;
  logic [DATA_W-1:0] per_hi_d, duty_hi_d, ao_hi_d;
  logic [CW-1:0]     period_q, duty_q, limit_q;
  logic [CW-1:0]     period_d, duty_d, limit_d;
  logic              en_q, en_d;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ref_a);
    return a == ADDR_W'(ref_a);
  endfunction

  always_comb begin
    sel.ao_hi   = wr_en && hit(wr_addr, A_AUTOOFF_HI);
    sel.ao_lo   = wr_en && hit(wr_addr, A_AUTOOFF_LO);
    sel.enable  = wr_en && hit(wr_addr, A_ENABLE);
    sel.per_lo  = wr_en && hit(wr_addr, A_PERIOD_LO);
    sel.per_hi  = wr_en && hit(wr_addr, A_PERIOD_HI);
    sel.duty_lo = wr_en && hit(wr_addr, A_DUTY_LO);
    sel.duty_hi = wr_en && hit(wr_addr, A_DUTY_HI);
  end

  always_comb begin
    per_hi_d  = sel.per_hi  ? wr_data : per_hi_q;
    duty_hi_d = sel.duty_hi ? wr_data : duty_hi_q;
    ao_hi_d   = sel.ao_hi   ? wr_data : ao_hi_q;
    period_d  = sel.per_lo  ? {per_hi_q, wr_data}  : period_q;
    duty_d    = sel.duty_lo ? {duty_hi_q, wr_data} : duty_q;
    limit_d   = sel.ao_lo   ? {ao_hi_q, wr_data}   : limit_q;
    if (sel.enable)     en_d = wr_data[0];
    else if (ao_expire) en_d = 1'b0;
    else                en_d = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_hi_q  <= '0;
      duty_hi_q <= '0;
      ao_hi_q   <= '1;
      period_q  <= '0;
      duty_q    <= '0;
      limit_q   <= '1;
      en_q      <= 1'b0;
    end else begin
      per_hi_q  <= per_hi_d;
      duty_hi_q <= duty_hi_d;
      ao_hi_q   <= ao_hi_d;
      period_q  <= period_d;
      duty_q    <= duty_d;
      limit_q   <= limit_d;
      en_q      <= en_d;
    end
  end

  assign en         = en_q;
  assign period     = period_q;
  assign duty_cfg   = duty_q;
  assign ao_limit   = limit_q;
  assign per_commit = sel.per_lo;
  assign en_write   = sel.enable;
  assign ao_commit  = sel.ao_lo;

  // R3
  period_staged_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit(wr_addr, A_PERIOD_HI)) |=> $stable(period_q));
endmodule

// File: rtl/pwm_ao_core.sv
module pwm_ao_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] duty_cfg,
  input  logic          per_commit,
  output logic          pwm_out
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] live_q, live_d;
  logic          run;

  assign run = en && (period != '0);

  always_comb begin
    cnt_d  = cnt_q;
    live_d = live_q;
    if (per_commit || !run) begin
      cnt_d  = '0;
      live_d = duty_cfg;
    end else if (tick) begin
      if (cnt_q >= period - CW'(1)) begin
        cnt_d  = '0;
        live_d = duty_cfg;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      live_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      live_q <= live_d;
    end
  end

  assign pwm_out = run && (cnt_q < live_q);

  // R4
  restart_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_commit |=> (cnt_q == '0));
  // R6
  phase_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < period));
  // R9
  zero_period_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) |-> !pwm_out);
endmodule

// File: rtl/pwm_ao_timer.sv
module pwm_ao_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic [CW-1:0] limit,
  input  logic          restart,
  output logic          expire
);
  logic [CW-1:0] ac_q, ac_d;
  logic          off;

  assign off = (limit == '1);

  always_comb begin
    ac_d = ac_q;
    if (restart || !en)                      ac_d = '0;
    else if (tick && !off && ac_q != '1)     ac_d = ac_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ac_q <= '0;
    else        ac_q <= ac_d;
  end

  assign expire = en && !off && (ac_q >= limit);

  // R11
  timer_frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off && en && !restart) |=> (ac_q == $past(ac_q)));
endmodule

// File: rtl/pwm_autooff.sv
module pwm_autooff #(
  parameter int TICK_DIV    = 8,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_out
);
  localparam int CW = 2 * DATA_W;

  logic [SYNC_STAGES-1:0] rs_q;
  logic                   rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_i = rs_q[SYNC_STAGES-1];

  logic          tick, en, per_commit, en_write, ao_commit, ao_expire;
  logic [CW-1:0] period, duty_cfg, ao_limit;

  pwm_ao_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_i), .tick(tick)
  );

  pwm_ao_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ao_expire(ao_expire), .en(en), .period(period), .duty_cfg(duty_cfg),
    .ao_limit(ao_limit), .per_commit(per_commit), .en_write(en_write),
    .ao_commit(ao_commit)
  );

  pwm_ao_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_i), .tick(tick), .en(en), .period(period),
    .duty_cfg(duty_cfg), .per_commit(per_commit), .pwm_out(pwm_out)
  );

  pwm_ao_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_i), .tick(tick), .en(en), .limit(ao_limit),
    .restart(en_write || ao_commit), .expire(ao_expire)
  );

  // R10
  autooff_clears_enable_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (ao_expire && !en_write) |=> !en);
  // R8
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (!en && !en_write) |=> !pwm_out);
endmodule

// File: tb/pwm_autooff_bench.sv
module pwm_autooff_bench;
  localparam int CLK_NS = 10;
  localparam int DIV    = 4;
  localparam int SYNC   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_out;

  int    n_run = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #(CLK_NS/2) clk = ~clk;

  pwm_autooff #(.TICK_DIV(DIV), .SYNC_STAGES(SYNC)) u_pwm_autooff (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  // behavioural reference model
  int m_rs, m_pre, m_phi, m_dhi, m_ahi, m_per, m_duty, m_lim, m_cnt, m_live, m_ac;
  bit m_en;

  function automatic bit m_out();
    return m_en && m_per != 0 && m_cnt < m_live;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 0; m_pre = 0; m_phi = 0; m_dhi = 0; m_ahi = 255;
      m_per = 0; m_duty = 0; m_lim = 65535; m_cnt = 0; m_live = 0; m_ac = 0; m_en = 0;
    end else if (m_rs < SYNC) begin
      m_rs++;
    end else begin
      automatic bit tk  = (m_pre == DIV - 1);
      automatic bit run = m_en && m_per != 0;
      automatic bit off = (m_lim == 65535);
      automatic bit exp_ = m_en && !off && m_ac >= m_lim;
      automatic bit w_en  = wr_en && wr_addr == 8'hA3;
      automatic bit w_plo = wr_en && wr_addr == 8'hA4;
      automatic bit w_alo = wr_en && wr_addr == 8'hA2;
      automatic int n_cnt = m_cnt, n_live = m_live, n_ac = m_ac;
      if (w_plo || !run) begin n_cnt = 0; n_live = m_duty; end
      else if (tk) begin
        if (m_cnt >= m_per - 1) begin n_cnt = 0; n_live = m_duty; end
        else n_cnt = m_cnt + 1;
      end
      if (w_en || w_alo || !m_en) n_ac = 0;
      else if (tk && !off) n_ac = m_ac + 1;
      m_cnt = n_cnt; m_live = n_live; m_ac = n_ac;
      if (w_en) m_en = wr_data[0];
      else if (exp_) m_en = 0;
      if (wr_en) begin
        case (wr_addr)
          8'hA1: m_ahi = wr_data;
          8'hA2: m_lim = m_ahi * 256 + wr_data;
          8'hA4: m_per = m_phi * 256 + wr_data;
          8'hA5: m_phi = wr_data;
          8'hA6: m_duty = m_dhi * 256 + wr_data;
          8'hA7: m_dhi = wr_data;
          default: ;
        endcase
      end
      m_pre = tk ? 0 : m_pre + 1;
    end
  end

  task automatic check(input bit got, input bit exp_v, input string req);
    n_run++;
    if (got !== exp_v) begin
      n_fail++;
      $display("FAIL %s: pwm_out=%0b expected %0b at %0t", req, got, exp_v, $time);
    end
  endtask

  task automatic check_int(input int got, input int exp_v, input string req);
    n_run++;
    if (got != exp_v) begin
      n_fail++;
      $display("FAIL %s: high clocks=%0d expected %0d at %0t", req, got, exp_v, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) check(pwm_out, m_out(), cur_req);
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int hc);
    hc = 0;
    repeat (n) begin
      @(negedge clk);
      #1;
      if (pwm_out) hc++;
    end
  endtask

  int hc;

  initial begin
    #(CLK_NS * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(6);
    cur_req = "R1";
    check(pwm_out, 1'b0, "R1");
    // R9: zero period stays low when enabled
    cur_req = "R9";
    wr(8'hA3, 8'h01);
    idle(20);
    check(pwm_out, 1'b0, "R9");
    wr(8'hA3, 8'h00);
    // R2 R6: period 10 ticks, duty 3
    cur_req = "R6";
    wr(8'hA5, 8'h00); wr(8'hA4, 8'd10);
    wr(8'hA7, 8'h00); wr(8'hA6, 8'd3);
    wr(8'hA3, 8'h01);
    idle(80);
    count_high(10 * DIV, hc);
    check_int(hc, 3 * DIV, "R6");
    // R1: no auto-off by default, still running after a long wait
    cur_req = "R1";
    idle(600);
    count_high(10 * DIV, hc);
    check_int(hc, 3 * DIV, "R1");
    // R3: staged period high does not change anything
    cur_req = "R3";
    wr(8'hA5, 8'h01);
    wr(8'hA7, 8'h02);
    idle(40);
    count_high(10 * DIV, hc);
    check_int(hc, 3 * DIV, "R3");
    // R4: commit new period 8
    cur_req = "R4";
    wr(8'hA5, 8'h00); wr(8'hA7, 8'h00);
    wr(8'hA4, 8'd8);
    check(pwm_out, 1'b1, "R4");
    idle(40);
    count_high(8 * DIV, hc);
    check_int(hc, 3 * DIV, "R4");
    // R5: duty 5 picked up at boundary
    cur_req = "R5";
    wr(8'hA6, 8'd5);
    idle(70);
    count_high(8 * DIV, hc);
    check_int(hc, 5 * DIV, "R5");
    // R7: duty above and equal to period
    cur_req = "R7";
    wr(8'hA6, 8'd9);
    idle(70);
    count_high(8 * DIV, hc);
    check_int(hc, 8 * DIV, "R7");
    wr(8'hA6, 8'd8);
    idle(70);
    count_high(8 * DIV, hc);
    check_int(hc, 8 * DIV, "R7");
    // R8: only bit 0 counts
    cur_req = "R8";
    wr(8'hA3, 8'hFE);
    count_high(8 * DIV, hc);
    check_int(hc, 0, "R8");
    wr(8'hA3, 8'h03);
    idle(40);
    count_high(8 * DIV, hc);
    check_int(hc, 8 * DIV, "R8");
    // R12: unmapped writes ignored
    cur_req = "R12";
    wr(8'h50, 8'h00); wr(8'hA8, 8'h00); wr(8'hA0, 8'h00);
    count_high(8 * DIV, hc);
    check_int(hc, 8 * DIV, "R12");
    // R10: limit 20 ticks
    cur_req = "R10";
    wr(8'hA6, 8'd3);
    wr(8'hA1, 8'h00); wr(8'hA2, 8'd20);
    idle(100);
    check(pwm_out, 1'b0, "R10");
    count_high(8 * DIV, hc);
    check_int(hc, 0, "R10");
    wr(8'hA3, 8'h01);
    check(pwm_out, 1'b1, "R10");
    idle(100);
    check(pwm_out, 1'b0, "R10");
    // R11: all-ones limit disables the timer
    cur_req = "R11";
    wr(8'hA1, 8'hFF); wr(8'hA2, 8'hFF);
    wr(8'hA3, 8'h01);
    idle(400);
    count_high(8 * DIV, hc);
    check_int(hc, 3 * DIV, "R11");
    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule